// File: doc/BRIEF.md
# Load/Store Address Generation and Data Extension Unit

This block handles the address and data side of a single load or store on a byte-addressed, little-endian 32-bit memory. It receives a base register value and an offset. The offset is either a zero-extended 12-bit immediate or a register value shifted left by a small amount. Mode bits select among three behaviours: a plain offset access, a pre-indexed access with base update, and a post-indexed access. A direction bit chooses whether the offset is added to or subtracted from the base.

On accepting a request, the unit computes three things: the access address, the updated base value, and whether the base is to be written back. It also checks that the access is aligned. An aligned access goes out as one word-addressed memory request with byte enables. Store data is replicated onto every lane of its size. Load data is taken from the addressed lane and sign- or zero-extended to 32 bits. A misaligned halfword or word access never reaches memory; it completes at once with a fault flag and no writeback.

The surrounding pipeline presents one request at a time on a valid/ready pair. It then waits for a single-cycle completion pulse that carries the load result, the writeback enable and the updated base value.

Top module: `ldst_agu`

## Requirements
- R1: With `req_pre`=1 and `req_wb`=0 (offset mode), memory is accessed at base plus offset, and `wb_en` stays 0 on completion.
- R2: With `req_pre`=1 and `req_wb`=1, memory is accessed at base plus offset, and on completion `wb_en`=1 with `wb_value` equal to that same address.
- R3: With `req_pre`=0 (post-index, `req_wb` ignored), memory is accessed at the unmodified base, and on completion `wb_en`=1 with `wb_value` = base plus offset.
- R4: With `req_use_reg`=0, the offset is `req_imm` zero-extended. With `req_use_reg`=1, the offset is `req_offreg` shifted left by `req_shamt` bit positions.
- R5: With `req_sub`=1, the offset is subtracted from the base instead of added. This applies to both the access address and `wb_value`.
- R6: With `req_signed`=1, a byte load (`req_size`=00) returns the addressed byte with its bit 7 copied into bits 31:8. A halfword load (`req_size`=01) returns the addressed halfword with its bit 15 copied into bits 31:16.
- R7: With `req_signed`=0, byte and halfword loads fill the upper bits with zero. The byte in lane k (read data bits 8k+7:8k) sits at address offset k, and lanes 0/1 form the halfword at offset 0. A word load (`req_size`=1x) returns the read data unchanged, and stores return `load_data`=0.
- R8: For a store, a byte is replicated into all four lanes and only the enable bit matching address bits 1:0 is set. A halfword is replicated into both halves, with enables 0011 for address bit 1 = 0 and 1100 for address bit 1 = 1. A word sets all four enables. Loads drive the same enables.
- R9: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, raises `align_fault` together with `done_valid` in the cycle after acceptance. In that case `mem_req` is never raised, `wb_en` stays 0 and `load_data` is 0.
- R10: `req_ready` is high only when no access is in flight. `mem_req` rises in the cycle after acceptance and holds its address, enables and write flag stable until `mem_ready` is sampled high. `done_valid` is a one-cycle pulse in the cycle after that.
- R11: `mem_addr` is the access address with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_pre | input | 1 | 1 = pre-index / offset mode, 0 = post-index |
| req_wb | input | 1 | Write back the base in pre-index mode |
| req_sub | input | 1 | Subtract the offset from the base |
| req_use_reg | input | 1 | Use the shifted register offset instead of the immediate |
| req_imm | input | 12 | Immediate offset |
| req_offreg | input | 32 | Register offset value |
| req_shamt | input | 5 | Left shift applied to the register offset |
| req_base | input | 32 | Base register value |
| req_wdata | input | 32 | Store data (right-aligned) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| done_valid | output | 1 | Completion pulse |
| align_fault | output | 1 | Access was misaligned (with done_valid) |
| load_data | output | 32 | Aligned and extended load result |
| wb_en | output | 1 | Base writeback enable (with done_valid) |
| wb_value | output | 32 | Updated base value |

## Verification
Address, enables, write flag and replicated store data belong to the memory request. They are due in the cycle after the request is accepted, so the bench samples them at the falling edge that follows the accepting rising edge. It then samples them again during any stall cycles, to confirm they have not moved. The load result, writeback enable and updated base are due one cycle after `mem_ready` is sampled, and the bench reads them at the next falling edge. It checks one cycle later that the completion pulse has dropped. A misaligned request skips the memory phase, so its fault, its missing writeback and the absence of `mem_req` are all checked in the cycle directly after acceptance.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORD2 = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_DONE = 2'd2
   } ldst_state_e;

   function automatic logic size_is_word(input logic [1:0] sz);
      return sz[1];
   endfunction

   function automatic logic size_is_half(input logic [1:0] sz);
      return (sz == SZ_HALF);
   endfunction

endpackage

// File: rtl/ldst_offset_gen.sv
module ldst_offset_gen #(
   parameter int ADDR_W   = 32,
   parameter int IMM_W    = 12,
   parameter int SHAMT_W  = 5,
   parameter bit SHIFT_EN = 1'b1
) (
   input  logic               use_reg,
   input  logic [IMM_W-1:0]   imm,
   input  logic [ADDR_W-1:0]  offreg,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [ADDR_W-1:0]  offset
);
   localparam int IMM_PAD = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] reg_term;
   logic [ADDR_W-1:0] imm_term;

   if (IMM_W >= ADDR_W) begin : g_bad_imm
      $error("ldst_offset_gen: IMM_W must be narrower than ADDR_W");
   end

   if (SHIFT_EN) begin : g_shift
      assign reg_term = offreg << shamt;
   end else begin : g_noshift
      logic unused_shamt;
      assign unused_shamt = ^shamt;
      assign reg_term = offreg;
   end

   assign imm_term = {{IMM_PAD{1'b0}}, imm};
   assign offset   = use_reg ? reg_term : imm_term;

endmodule

// File: rtl/ldst_addr_calc.sv
module ldst_addr_calc #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   input  logic              sub,
   input  logic              pre,
   input  logic              wb_req,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] upd_addr,
   output logic              wb_en
);
   logic [ADDR_W-1:0] sum_val;
   logic [ADDR_W-1:0] dif_val;

   assign sum_val  = base + offset;
   assign dif_val  = base - offset;
   assign upd_addr = sub ? dif_val : sum_val;
   // pre-index uses the updated value, post-index the untouched base
   assign acc_addr = pre ? upd_addr : base;
   // post-index always updates the base
   assign wb_en    = ~pre | wb_req;

endmodule

// File: rtl/ldst_lane_map.sv
module ldst_lane_map
   import ldst_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LO_W  = $clog2(LANES)
) (
   input  logic [1:0]        size,
   input  logic [LO_W-1:0]   lo,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] lane_data,
   output logic              misalign
);
   logic is_word;
   logic is_half;

   assign is_word  = size_is_word(size);
   assign is_half  = size_is_half(size);
   assign misalign = (is_half & lo[0]) | (is_word & (lo != '0));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [LO_W-1:0] LANE_IDX = LO_W'(i);
      localparam logic            HALF_HI  = 1'((i / 2) % 2);
      localparam int              HALF_SUB = i % 2;

      assign be[i] = is_word ? 1'b1 :
                     is_half ? (lo[1] == HALF_HI) :
                               (lo == LANE_IDX);

      assign lane_data[8*i +: 8] = is_word ? wdata[8*i +: 8] :
                                   is_half ? wdata[8*HALF_SUB +: 8] :
                                             wdata[7:0];
   end

endmodule

// File: rtl/ldst_load_ext.sv
module ldst_load_ext
   import ldst_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LO_W  = $clog2(LANES)
) (
   input  logic [1:0]        size,
   input  logic              sgn,
   input  logic [LO_W-1:0]   lo,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] shifted;
   logic              b_fill;
   logic              h_fill;

   // little endian: lowest address sits in the lowest lane
   assign shifted = rdata >> {lo, 3'b000};
   assign b_fill  = sgn & shifted[7];
   assign h_fill  = sgn & shifted[15];

   always_comb begin
      if (size_is_word(size)) begin
         data = rdata;
      end else if (size_is_half(size)) begin
         data = {{(DATA_W-16){h_fill}}, shifted[15:0]};
      end else begin
         data = {{(DATA_W-8){b_fill}}, shifted[7:0]};
      end
   end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int IMM_W    = 12,
   parameter int SHAMT_W  = 5,
   parameter bit SHIFT_EN = 1'b1,
   localparam int LANES   = DATA_W / 8,
   localparam int LO_W    = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_store,
   input  logic [1:0]         req_size,
   input  logic               req_signed,
   input  logic               req_pre,
   input  logic               req_wb,
   input  logic               req_sub,
   input  logic               req_use_reg,
   input  logic [IMM_W-1:0]   req_imm,
   input  logic [ADDR_W-1:0]  req_offreg,
   input  logic [SHAMT_W-1:0] req_shamt,
   input  logic [ADDR_W-1:0]  req_base,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [LANES-1:0]   mem_be,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic               mem_ready,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               done_valid,
   output logic               align_fault,
   output logic [DATA_W-1:0]  load_data,
   output logic               wb_en,
   output logic [ADDR_W-1:0]  wb_value
);
   if (DATA_W != 32) begin : g_bad_data
      $error("ldst_agu: DATA_W must be 32 for byte/half/word sizes");
   end
   if (ADDR_W < DATA_W) begin : g_bad_addr
      $error("ldst_agu: ADDR_W must be at least DATA_W");
   end
   if (SHAMT_W > $clog2(ADDR_W)) begin : g_bad_shamt
      $error("ldst_agu: SHAMT_W wider than a full address shift");
   end

   // request-side combinational path
   logic [ADDR_W-1:0] c_offset;
   logic [ADDR_W-1:0] c_acc;
   logic [ADDR_W-1:0] c_upd;
   logic              c_wb;
   logic [LANES-1:0]  c_be;
   logic [DATA_W-1:0] c_lanes;
   logic              c_mis;

   ldst_offset_gen #(
      .ADDR_W  (ADDR_W),
      .IMM_W   (IMM_W),
      .SHAMT_W (SHAMT_W),
      .SHIFT_EN(SHIFT_EN)
   ) u_off (
      .use_reg(req_use_reg),
      .imm    (req_imm),
      .offreg (req_offreg),
      .shamt  (req_shamt),
      .offset (c_offset)
   );

   ldst_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
      .base    (req_base),
      .offset  (c_offset),
      .sub     (req_sub),
      .pre     (req_pre),
      .wb_req  (req_wb),
      .acc_addr(c_acc),
      .upd_addr(c_upd),
      .wb_en   (c_wb)
   );

   ldst_lane_map #(.DATA_W(DATA_W)) u_lane (
      .size     (req_size),
      .lo       (c_acc[LO_W-1:0]),
      .wdata    (req_wdata),
      .be       (c_be),
      .lane_data(c_lanes),
      .misalign (c_mis)
   );

   // registered access state
   ldst_state_e       state;
   logic [ADDR_W-1:0] r_acc;
   logic [ADDR_W-1:0] r_upd;
   logic              r_wb;
   logic [1:0]        r_size;
   logic              r_signed;
   logic              r_store;
   logic [LANES-1:0]  r_be;
   logic [DATA_W-1:0] r_wdata;
   logic              r_fault;
   logic [DATA_W-1:0] r_rdata;
   logic              accept;

   assign accept = req_valid & (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         r_acc    <= '0;
         r_upd    <= '0;
         r_wb     <= 1'b0;
         r_size   <= 2'b00;
         r_signed <= 1'b0;
         r_store  <= 1'b0;
         r_be     <= '0;
         r_wdata  <= '0;
         r_fault  <= 1'b0;
         r_rdata  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  r_acc    <= c_acc;
                  r_upd    <= c_upd;
                  r_wb     <= c_wb;
                  r_size   <= req_size;
                  r_signed <= req_signed;
                  r_store  <= req_store;
                  r_be     <= c_be;
                  r_wdata  <= c_lanes;
                  r_fault  <= c_mis;
                  r_rdata  <= '0;
                  state    <= c_mis ? ST_DONE : ST_MEM;
               end
            end
            ST_MEM: begin
               if (mem_ready) begin
                  r_rdata <= mem_rdata;
                  state   <= ST_DONE;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [DATA_W-1:0] ext_data;

   ldst_load_ext #(.DATA_W(DATA_W)) u_ext (
      .size (r_size),
      .sgn  (r_signed),
      .lo   (r_acc[LO_W-1:0]),
      .rdata(r_rdata),
      .data (ext_data)
   );

   logic in_mem;
   logic in_done;

   assign in_mem  = (state == ST_MEM);
   assign in_done = (state == ST_DONE);

   assign req_ready   = (state == ST_IDLE);
   assign mem_req     = in_mem;
   assign mem_we      = in_mem & r_store;
   assign mem_addr    = {r_acc[ADDR_W-1:LO_W], {LO_W{1'b0}}};
   assign mem_be      = in_mem ? r_be : '0;
   assign mem_wdata   = r_wdata;
   assign done_valid  = in_done;
   assign align_fault = in_done & r_fault;
   assign wb_en       = in_done & r_wb & ~r_fault;
   assign wb_value    = r_upd;
   assign load_data   = (in_done & ~r_store & ~r_fault) ? ext_data : '0;

endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LANES-1:0]  mem_be,
   input logic              done_valid,
   input logic              align_fault,
   input logic              wb_en,
   input logic [DATA_W-1:0] load_data,
   input logic [1:0]        c_size,
   input logic              c_signed,
   input logic              c_store
);
   logic byte_load;
   logic half_load;

   assign byte_load = done_valid & ~align_fault & ~c_store & (c_size == 2'b00);
   assign half_load = done_valid & ~align_fault & ~c_store & (c_size == 2'b01);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)); // R10
   AST_DONE_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> done_valid && !mem_req); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R10
   AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !wb_en && !mem_req && (load_data == '0)); // R9
   AST_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R11
   AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == ((c_size == 2'b00) ? 1 : (c_size == 2'b01) ? 2 : 4))); // R8
   AST_SBYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      byte_load && c_signed |-> (load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}})); // R6
   AST_SHALF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      half_load && c_signed |-> (load_data[DATA_W-1:16] == {(DATA_W-16){load_data[15]}})); // R6
   AST_UBYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      byte_load && !c_signed |-> (load_data[DATA_W-1:8] == '0)); // R7
   AST_UHALF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      half_load && !c_signed |-> (load_data[DATA_W-1:16] == '0)); // R7

endmodule

bind ldst_agu ldst_agu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_ready  (mem_ready),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_be     (mem_be),
   .done_valid (done_valid),
   .align_fault(align_fault),
   .wb_en      (wb_en),
   .load_data  (load_data),
   .c_size     (r_size),
   .c_signed   (r_signed),
   .c_store    (r_store)
);

// File: tb/ldst_agu_test.sv
`timescale 1ns/1ps
module ldst_agu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic        req_pre = 1'b0;
   logic        req_wb = 1'b0;
   logic        req_sub = 1'b0;
   logic        req_use_reg = 1'b0;
   logic [11:0] req_imm = '0;
   logic [31:0] req_offreg = '0;
   logic [4:0]  req_shamt = '0;
   logic [31:0] req_base = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done_valid;
   logic        align_fault;
   logic [31:0] load_data;
   logic        wb_en;
   logic [31:0] wb_value;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ldst_agu uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_size(req_size), .req_signed(req_signed),
      .req_pre(req_pre), .req_wb(req_wb), .req_sub(req_sub),
      .req_use_reg(req_use_reg), .req_imm(req_imm), .req_offreg(req_offreg),
      .req_shamt(req_shamt), .req_base(req_base), .req_wdata(req_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .done_valid(done_valid), .align_fault(align_fault), .load_data(load_data),
      .wb_en(wb_en), .wb_value(wb_value)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // One access; expected values derived from the requirements.
   task automatic do_access(input string tag, input logic st, input logic [1:0] sz, input logic sgn,
                            input logic pre, input logic wb, input logic sub, input logic ureg,
                            input logic [11:0] imm, input logic [31:0] oreg, input logic [4:0] sh,
                            input logic [31:0] base, input logic [31:0] wd, input logic [31:0] rd,
                            input int stall);
      logic [31:0] off, upd, acc, be32, wdx, ldx, lane;
      logic        wbx, bad;
      off  = ureg ? (oreg << sh) : {20'd0, imm};
      upd  = sub ? base - off : base + off;
      acc  = pre ? upd : base;
      wbx  = !pre || wb;
      bad  = (sz == 2'b01 && acc[0]) || (sz[1] && acc[1:0] != 2'b00);
      lane = rd >> (8 * acc[1:0]);
      if (sz[1]) begin
         be32 = 32'hF; wdx = wd; ldx = rd;
      end else if (sz == 2'b01) begin
         be32 = acc[1] ? 32'hC : 32'h3; wdx = {2{wd[15:0]}};
         ldx  = sgn ? {{16{lane[15]}}, lane[15:0]} : {16'd0, lane[15:0]};
      end else begin
         be32 = 32'h1 << acc[1:0]; wdx = {4{wd[7:0]}};
         ldx  = sgn ? {{24{lane[7]}}, lane[7:0]} : {24'd0, lane[7:0]};
      end
      if (st) ldx = '0;

      @(negedge clk);
      chk("R10", "req_ready idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sgn;
      req_pre = pre; req_wb = wb; req_sub = sub; req_use_reg = ureg;
      req_imm = imm; req_offreg = oreg; req_shamt = sh; req_base = base; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
         chk("R9", "align_fault", {31'd0, align_fault}, 32'd1);
         chk("R9", "done_valid", {31'd0, done_valid}, 32'd1);
         chk("R9", "mem_req", {31'd0, mem_req}, 32'd0);
         chk("R9", "wb_en", {31'd0, wb_en}, 32'd0);
         chk("R9", "load_data", load_data, 32'd0);
      end else begin
         chk("R10", "mem_req", {31'd0, mem_req}, 32'd1);
         chk(tag, "mem_addr", mem_addr, {acc[31:2], 2'b00});
         chk("R11", "mem_addr low", {30'd0, mem_addr[1:0]}, 32'd0);
         chk("R8", "mem_be", {28'd0, mem_be}, be32);
         chk("R8", "mem_we", {31'd0, mem_we}, {31'd0, st});
         if (st) chk("R8", "mem_wdata", mem_wdata, wdx);
         for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R10", "stall mem_req", {31'd0, mem_req}, 32'd1);
            chk("R10", "stall mem_addr", mem_addr, {acc[31:2], 2'b00});
            chk("R10", "stall done", {31'd0, done_valid}, 32'd0);
         end
         mem_ready = 1'b1; mem_rdata = rd;
         @(negedge clk);
         mem_ready = 1'b0; mem_rdata = '0;
         chk("R10", "done_valid", {31'd0, done_valid}, 32'd1);
         chk("R10", "mem_req dropped", {31'd0, mem_req}, 32'd0);
         chk("R9", "no fault", {31'd0, align_fault}, 32'd0);
         chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, wbx});
         if (wbx) chk(tag, "wb_value", wb_value, upd);
         chk(tag, "load_data", load_data, ldx);
      end
      @(negedge clk);
      chk("R10", "done pulse ends", {31'd0, done_valid}, 32'd0);
      chk("R10", "ready again", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic t_reset();
      chk("R10", "reset req_ready", {31'd0, req_ready}, 32'd1);
      chk("R10", "reset mem_req", {31'd0, mem_req}, 32'd0);
      chk("R10", "reset done", {31'd0, done_valid}, 32'd0);
      chk("R9", "reset fault", {31'd0, align_fault}, 32'd0);
      chk("R2", "reset wb_en", {31'd0, wb_en}, 32'd0);
   endtask

   task automatic t_offset_mode();  // R1
      do_access("R1", 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd32, 0, 0, 32'h0000_1000, 0, 32'hCAFE_F00D, 0);
      do_access("R1", 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'hFFC, 0, 0, 32'h0000_0000, 0, 32'h1234_5678, 0);
   endtask

   task automatic t_pre_wb();  // R2
      do_access("R2", 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'd4, 0, 0, 32'h0000_2000, 32'hDEAD_BEEF, 0, 1);
   endtask

   task automatic t_post();  // R3, req_wb ignored
      do_access("R3", 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd8, 0, 0, 32'h0000_3000, 0, 32'hA5A5_5A5A, 0);
      do_access("R3", 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'd12, 0, 0, 32'h0000_3010, 0, 32'h0F0F_F0F0, 0);
   endtask

   task automatic t_reg_shift();  // R4
      do_access("R4", 1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'hFFF, 32'd5, 5'd2, 32'h0000_4000, 0, 32'h1111_2222, 2);
      do_access("R4", 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h0000_0003, 5'd4, 32'h0000_4100, 0, 32'h3333_4444, 0);
   endtask

   task automatic t_subtract();  // R5
      do_access("R5", 1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h010, 0, 0, 32'h0000_0100, 0, 32'h5555_6666, 0);
      do_access("R5", 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 32'd2, 5'd3, 32'h0000_0200, 0, 32'h7777_8888, 0);
   endtask

   task automatic t_signed_load();  // R6
      do_access("R6", 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd3, 0, 0, 32'h0000_5000, 0, 32'h8011_2233, 0);
      do_access("R6", 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd2, 0, 0, 32'h0000_5000, 0, 32'h9ABC_1234, 0);
      do_access("R6", 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd1, 0, 0, 32'h0000_5000, 0, 32'hFF7F_00FF, 0);
   endtask

   task automatic t_unsigned_load();  // R7
      do_access("R7", 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd3, 0, 0, 32'h0000_5000, 0, 32'h8011_2233, 0);
      do_access("R7", 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd0, 0, 0, 32'h0000_5000, 0, 32'h8011_22F3, 0);
      do_access("R7", 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd0, 0, 0, 32'h0000_5000, 0, 32'h9ABC_F234, 0);
      do_access("R7", 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'd4, 0, 0, 32'h0000_5000, 0, 32'h8000_0001, 0);
   endtask

   task automatic t_store_lanes();  // R8
      do_access("R8", 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd2, 0, 0, 32'h0000_6000, 32'h1234_56AB, 0, 0);
      do_access("R8", 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd3, 0, 0, 32'h0000_6000, 32'h0000_00C4, 0, 0);
      do_access("R8", 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd2, 0, 0, 32'h0000_6000, 32'hFFFF_BEEF, 0, 0);
      do_access("R8", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd6, 0, 0, 32'h0000_6008, 32'h0000_1357, 0, 1);
   endtask

   task automatic t_faults();  // R9
      do_access("R9", 1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'd2, 0, 0, 32'h0000_7000, 0, 0, 0);
      do_access("R9", 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'd1, 0, 0, 32'h0000_7000, 32'h1, 0, 0);
      do_access("R9", 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd4, 0, 0, 32'h0000_7001, 0, 0, 0);
      // odd byte address is legal
      do_access("R9", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'd4, 0, 0, 32'h0000_7001, 0, 32'h0000_AB00, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_offset_mode();
      t_pre_wb();
      t_post();
      t_reg_shift();
      t_subtract();
      t_signed_load();
      t_unsigned_load();
      t_store_lanes();
      t_faults();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL R10 watchdog act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule